// File: doc/BRIEF.md
# 4B/5B Stream Encoder and Decoder

This block converts between nibble-wide transmit data and five-bit code-groups for a 100 Mb/s physical-layer stream. On the transmit side it frames each packet itself. A rising transmit-enable causes the first two nibbles, which are preamble, to be replaced by the start pair /J/K/. Every nibble after that is mapped to its five-bit data code. When enable falls, the end pair /T/R/ is appended. Idle /I/ fills the line between packets. An error strobe raised during a frame turns that nibble into the halt code /H/.

The receive side takes one code-group per cycle. It opens a frame on /J/ followed by /K/ and reports each data code as a nibble with a valid flag. It closes the frame on /T/. It raises an error flag for any code that is not one of the 22 legal codes, and for a control code that appears inside a frame. Both paths register their outputs and advance one code-group per symbol clock. Serialization and line coding happen after this block.

Top module: `nibble_codec`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_code_o is idle 11111, and rx_dv_o and rx_er_o are 0.
- R2: If tx_en_i is sampled high while the encoder is idle, tx_code_o is /J/ 11000 after that edge and /K/ 10001 after the next edge. The nibbles present at those two edges are discarded.
- R3: After /K/, each edge that samples tx_en_i high puts the data code of txd_i on tx_code_o after that edge. The data codes for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: When tx_er_i is high at an edge that samples a data nibble, tx_code_o is /H/ 00100 in place of the data code.
- R5: The first edge that samples tx_en_i low after data gives /T/ 01101, and the next edge gives /R/ 00111. The output is then idle 11111. tx_er_i has no effect while the encoder is idle.
- R6: On the receive side, /J/ followed by /K/ opens a frame. Each data code inside a frame gives rx_dv_o=1, rx_er_o=0 and rxd_o equal to its nibble, one edge after the code is present.
- R7: /T/ closes a frame. rx_dv_o is 0 one edge after /T/ and stays 0 until the next /J/K/.
- R8: Each of the 10 five-bit values outside the legal set gives rx_er_o=1 one edge later, inside or outside a frame. The legal set is the 16 data codes plus 11111, 11000, 10001, 01101, 00111 and 00100. A legal code outside a frame gives rx_dv_o=0 and rx_er_o=0.
- R9: Inside a frame, /H/ or a /J/, /K/ or /R/ code gives rx_dv_o=1 and rx_er_o=1. Idle inside a frame gives rx_er_o=1 and rx_dv_o=0, and closes the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable |
| tx_er_i | input | 1 | Transmit error strobe |
| txd_i | input | 4 | Transmit nibble |
| tx_code_o | output | 5 | Encoded code-group |
| rx_code_i | input | 5 | Received code-group |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| rxd_o | output | 4 | Decoded nibble |

## Verification
A wrong encoder state shows on tx_code_o at the very next edge. A stuck or skipped state drops /K/ or /R/, repeats /J/, or lets data through without delimiters. A bad mapping entry changes one code-group in the cycle where that nibble is sampled. On the receive side, a wrong frame flag shows one edge later as rx_dv_o high outside a frame or low inside one. A missing legality check shows as rx_er_o staying low one edge after an illegal code. The sweeps cover every nibble value in loopback and every five-bit value both inside and outside a frame, so each of these faults reaches a port within one or two cycles of its cause.

// File: rtl/nibble_codec_pkg.sv
package nibble_codec_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] SYM_I = 5'b11111;
  localparam logic [CODE_W-1:0] SYM_J = 5'b11000;
  localparam logic [CODE_W-1:0] SYM_K = 5'b10001;
  localparam logic [CODE_W-1:0] SYM_T = 5'b01101;
  localparam logic [CODE_W-1:0] SYM_R = 5'b00111;
  localparam logic [CODE_W-1:0] SYM_H = 5'b00100;

  typedef enum logic [1:0] {ENC_IDLE, ENC_SSD2, ENC_DATA, ENC_ESD2} enc_state_e;

  typedef struct packed {
    logic             is_data;
    logic [NIB_W-1:0] nib;
  } dec_res_t;

  function automatic logic [CODE_W-1:0] nib_to_code(input logic [NIB_W-1:0] n);
    logic [CODE_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;  4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;  4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;  4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;  4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;  4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;  4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;  4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;  default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic dec_res_t code_to_nib(input logic [CODE_W-1:0] c);
    dec_res_t r;
    r = '0;
    for (int i = 0; i < (1 << NIB_W); i++) begin
      if (nib_to_code(NIB_W'(i)) == c) begin
        r.is_data = 1'b1;
        r.nib     = NIB_W'(i);
      end
    end
    return r;
  endfunction

  function automatic logic is_ctrl(input logic [CODE_W-1:0] c);
    return (c == SYM_I) || (c == SYM_J) || (c == SYM_K) ||
           (c == SYM_T) || (c == SYM_R) || (c == SYM_H);
  endfunction

  function automatic logic is_legal(input logic [CODE_W-1:0] c);
    dec_res_t r;
    r = code_to_nib(c);
    return r.is_data || is_ctrl(c);
  endfunction
endpackage

// File: rtl/nibble_codec_tx.sv
module nibble_codec_tx
  import nibble_codec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              er_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [CODE_W-1:0] code_o
);
  enc_state_e        state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    state_d = state_q;
    code_d  = SYM_I;
    unique case (state_q)
      ENC_IDLE: if (en_i) begin
        code_d  = SYM_J;
        state_d = ENC_SSD2;
      end
      ENC_SSD2: begin
        code_d  = SYM_K;
        state_d = ENC_DATA;
      end
      ENC_DATA: if (en_i) begin
        code_d = er_i ? SYM_H : nib_to_code(nib_i);
      end else begin
        code_d  = SYM_T;
        state_d = ENC_ESD2;
      end
      default: begin
        code_d  = SYM_R;
        state_d = ENC_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENC_IDLE;
      code_q  <= SYM_I;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end

  assign code_o = code_q;

  // R2
  k_after_j_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == SYM_K) |-> ($past(code_q) == SYM_J));
  // R5
  r_after_t_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == SYM_T) |=> (code_q == SYM_R));
  // R3
  tx_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_legal(code_q));
endmodule

// File: rtl/nibble_codec_rx.sv
module nibble_codec_rx
  import nibble_codec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              dv_o,
  output logic              er_o,
  output logic [NIB_W-1:0]  nib_o
);
  logic [CODE_W-1:0] prev_q;
  logic              frame_q, frame_d;
  logic              dv_d, er_d;
  logic [NIB_W-1:0]  nib_d;
  logic              dv_q, er_q;
  logic [NIB_W-1:0]  nib_q;
  dec_res_t          dec;

  assign dec = code_to_nib(code_i);

  always_comb begin
    frame_d = frame_q;
    dv_d    = 1'b0;
    er_d    = !is_legal(code_i);
    nib_d   = '0;
    if (!frame_q) begin
      if (prev_q == SYM_J && code_i == SYM_K) frame_d = 1'b1;
    end else if (code_i == SYM_T) begin
      frame_d = 1'b0;
    end else if (code_i == SYM_I) begin
      frame_d = 1'b0;
      er_d    = 1'b1;
    end else if (dec.is_data) begin
      dv_d  = 1'b1;
      nib_d = dec.nib;
    end else begin
      // halt, stray control or illegal code inside a frame
      dv_d = 1'b1;
      er_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= SYM_I;
      frame_q <= 1'b0;
      dv_q    <= 1'b0;
      er_q    <= 1'b0;
      nib_q   <= '0;
    end else begin
      prev_q  <= code_i;
      frame_q <= frame_d;
      dv_q    <= dv_d;
      er_q    <= er_d;
      nib_q   <= nib_d;
    end
  end

  assign dv_o  = dv_q;
  assign er_o  = er_q;
  assign nib_o = nib_q;

  // R8
  bad_code_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_legal(code_i) |=> er_q);
  // R7
  end_clears_dv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == SYM_T) |=> !dv_q);
  // R6
  dv_needs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_q |-> $past(frame_q));
endmodule

// File: rtl/nibble_codec.sv
module nibble_codec
  import nibble_codec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  input  logic [NIB_W-1:0]  txd_i,
  output logic [CODE_W-1:0] tx_code_o,
  input  logic [CODE_W-1:0] rx_code_i,
  output logic              rx_dv_o,
  output logic              rx_er_o,
  output logic [NIB_W-1:0]  rxd_o
);
  nibble_codec_tx u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_en_i),
    .er_i   (tx_er_i),
    .nib_i  (txd_i),
    .code_o (tx_code_o)
  );

  nibble_codec_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (rx_code_i),
    .dv_o   (rx_dv_o),
    .er_o   (rx_er_o),
    .nib_o  (rxd_o)
  );
endmodule

// File: tb/nibble_codec_bench.sv
module nibble_codec_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = '0;
  logic [4:0] tx_code, rx_drv = 5'b11111, rx_code;
  logic       loop = 1'b1;
  logic       rx_dv, rx_er;
  logic [3:0] rxd;
  int         checks = 0, errors = 0;

  logic       pend_dv = 1'b0, pend_er = 1'b0, pend_nib_chk = 1'b0;
  logic [3:0] pend_nib = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rx_code = loop ? tx_code : rx_drv;

  nibble_codec u_nibble_codec (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .tx_er_i(tx_er), .txd_i(txd),
    .tx_code_o(tx_code), .rx_code_i(rx_code), .rx_dv_o(rx_dv), .rx_er_o(rx_er), .rxd_o(rxd)
  );

  function automatic logic [4:0] ref_code(input logic [3:0] n);
    logic [4:0] t [16];
    t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
          5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic int ref_nib(input logic [4:0] c);
    for (int i = 0; i < 16; i++) if (ref_code(4'(i)) == c) return i;
    return -1;
  endfunction

  function automatic logic ref_ctrl(input logic [4:0] c);
    return c == 5'b11111 || c == 5'b11000 || c == 5'b10001 ||
           c == 5'b01101 || c == 5'b00111 || c == 5'b00100;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // loopback step: check code now, decoder result of previous code, then queue next
  task automatic lb_step(input string req, input logic [4:0] exp_code,
                         input logic dv, input logic er, input logic nchk, input logic [3:0] nib);
    tick();
    chk(req, tx_code, exp_code);
    chk("R6/R7 rx_dv", rx_dv, pend_dv);
    chk("R6/R9 rx_er", rx_er, pend_er);
    if (pend_nib_chk) chk("R6 rxd", rxd, pend_nib);
    pend_dv = dv; pend_er = er; pend_nib_chk = nchk; pend_nib = nib;
  endtask

  task automatic send_frame(input int len, input int seed, input int er_pos);
    tx_en = 1'b1; txd = 4'h5; tx_er = 1'b0;
    lb_step("R2 J", 5'b11000, 1'b0, 1'b0, 1'b0, '0);
    txd = 4'hD;
    lb_step("R2 K", 5'b10001, 1'b0, 1'b0, 1'b0, '0);
    for (int i = 0; i < len; i++) begin
      txd = 4'((i * 7 + seed) & 15);
      tx_er = (i == er_pos);
      if (tx_er) lb_step("R4 halt", 5'b00100, 1'b1, 1'b1, 1'b0, '0);
      else       lb_step("R3 data", ref_code(txd), 1'b1, 1'b0, 1'b1, txd);
    end
    tx_en = 1'b0; tx_er = 1'b0;
    lb_step("R5 T", 5'b01101, 1'b0, 1'b0, 1'b0, '0);
    lb_step("R5 R", 5'b00111, 1'b0, 1'b0, 1'b0, '0);
    tx_er = 1'b1;
    lb_step("R5 idle", 5'b11111, 1'b0, 1'b0, 1'b0, '0);
    tx_er = 1'b0;
    lb_step("R5 idle", 5'b11111, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    chk("R1 tx reset", tx_code, 5'b11111);
    chk("R1 dv reset", rx_dv, 0);
    chk("R1 er reset", rx_er, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 tx after reset", tx_code, 5'b11111);
    chk("R1 dv after reset", rx_dv, 0);

    // loopback frames: all nibbles, halts at different places, short frames
    send_frame(16, 0, -1);
    send_frame(16, 3, 0);
    send_frame(5, 9, 4);
    send_frame(1, 15, -1);
    send_frame(0, 0, -1);
    send_frame(20, 1, 7);

    // decoder alone: every code outside a frame
    loop = 1'b0;
    tick();
    for (int c = 0; c < 32; c++) begin
      rx_drv = 5'(c);
      tick();
      chk("R8 idle err", rx_er, !(ref_nib(5'(c)) >= 0 || ref_ctrl(5'(c))));
      chk("R8 idle dv", rx_dv, 0);
    end
    // every code inside a frame
    for (int c = 0; c < 32; c++) begin
      rx_drv = 5'b11111; tick();
      rx_drv = 5'b11000; tick();
      rx_drv = 5'b10001; tick();
      rx_drv = 5'(c);    tick();
      if (ref_nib(5'(c)) >= 0) begin
        chk("R6 frame dv", rx_dv, 1);
        chk("R6 frame er", rx_er, 0);
        chk("R6 frame nib", rxd, ref_nib(5'(c)));
      end else if (c == 5'b01101) begin
        chk("R7 T dv", rx_dv, 0);
        chk("R7 T er", rx_er, 0);
      end else if (c == 5'b11111) begin
        chk("R9 idle er", rx_er, 1);
        chk("R9 idle dv", rx_dv, 0);
      end else begin
        chk("R9/R8 bad er", rx_er, 1);
        chk("R9/R8 bad dv", rx_dv, 1);
      end
      rx_drv = 5'b01101; tick();
      chk("R7 closed dv", rx_dv, 0);
      rx_drv = 5'b11110; tick();
      chk("R7 after close dv", rx_dv, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule